// File: doc/BRIEF.md
# Triple Compare Tick Timer Bank

This block holds three independent 32-bit up-counters that advance on a one-cycle pulse at 1 MHz. A compare value written in microseconds sets when each timer fires. When a timer's count equals its compare value on a tick, the timer raises a sticky flag. If its auto-clear option is on, the counter also returns to zero, which gives a periodic interrupt every compare+1 ticks. The three timer flags and an abort input share one active-low interrupt line. A status word shows software which of the four sources is pending.

Software reaches the bank through a plain 16-bit register port. Each 32-bit quantity appears as a low word and a high word. A write to the high word of a counter is staged. The following low-word write loads both halves into the counter in one cycle. Reads are combinational on the current address. A write takes effect at the clock edge on which `reg_we` is sampled high. Every port is a plain control or status pin: no data stream enters or leaves the block, so there is no valid/ready handshake and no back-pressure.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every control word, counter half and compare half reads 0x0000, the status word reads 0 and `irq_n` is high.
- R2: The control word of timer t is at word address 8t. Bit 0 is run, bit 1 is auto-clear and bit 2 is interrupt enable. A running counter increments by one on each cycle with `tick` high. It holds its value when `tick` is low or when run is 0.
- R3: With auto-clear off, a counter steps from 0xFFFFFFFF to 0. It also keeps counting past a compare match.
- R4: A tick that finds a running counter equal to its compare value sets status bit t. The status word is at address 24: bits 0 to 2 are the timers and bit 3 is the abort.
- R5: With auto-clear on, the matching tick loads 0 into the counter instead of incrementing it. The flag then recurs every compare+1 ticks.
- R6: The counter low word is at 8t+1 and the high word at 8t+2. A high-word write alone leaves the counter unchanged. A low-word write loads {last high word written, low data} in one cycle.
- R7: The compare low word (8t+3) and high word (8t+4) are written and read independently.
- R8: `irq_n` is low exactly while the abort status bit is set, or while some timer status bit is set and that timer's interrupt enable is 1. A timer flag whose enable is 0 still shows in status but leaves `irq_n` high.
- R9: The abort input sets status bit 3 on every cycle it is high, and the bit stays set after the input falls.
- R10: Writing the status word clears each bit written as 1 and leaves the others alone. A source active in the same cycle wins over the clear.
- R11: The timers are independent: a write or match on one timer leaves the other timers' counters and flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at 1 MHz that advances running counters |
| abort_in | input | 1 | Abort request, level sensitive |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
Every result of this block is due at the first rising edge that samples its cause. A tick, a register write or a high abort changes counters, flags and the status word at that edge. `irq_n` and `reg_rdata` follow combinationally from the registered state. The bench therefore drives inputs on the falling edge and holds them through one rising edge. It reads back on the next falling edge, so each check sees exactly the state after one edge. Match and wrap cases tick one pulse at a time, so the cycle where a flag must first appear is checked on its own.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef struct packed {
    logic irq_en;
    logic autoclr;
    logic run;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_W      = 3;
  localparam int unsigned SLOT_WORDS  = 8;
  localparam logic [2:0]  F_CTRL      = 3'd0;
  localparam logic [2:0]  F_CNT_LO    = 3'd1;
  localparam logic [2:0]  F_CNT_HI    = 3'd2;
  localparam logic [2:0]  F_CMP_LO    = 3'd3;
  localparam logic [2:0]  F_CMP_HI    = 3'd4;

endpackage

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ctrl_we,
  input  logic              cnt_lo_we,
  input  logic              cnt_hi_we,
  input  logic              cmp_lo_we,
  input  logic              cmp_hi_we,
  input  logic [HALF_W-1:0] wdata,
  output tmr_ctrl_t         ctrl,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  cmp,
  output logic              hit
);

  logic [HALF_W-1:0] hi_stage;
  logic              at_cmp;

  assign at_cmp = (count == cmp);
  assign hit    = tick && ctrl.run && at_cmp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      hi_stage <= '0;
    end else begin
      if (ctrl_we)   ctrl     <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
      if (cnt_hi_we) hi_stage <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (cnt_lo_we) begin
      count <= {hi_stage, wdata};
    end else if (tick && ctrl.run) begin
      if (ctrl.autoclr && at_cmp) count <= '0;
      else                        count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= '0;
    end else begin
      if (cmp_lo_we) cmp[HALF_W-1:0]     <= wdata;
      if (cmp_hi_we) cmp[CNT_W-1:HALF_W] <= wdata;
    end
  end

  // R2 / R3: one step per tick, wrapping naturally
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl.run && !cnt_lo_we && !(ctrl.autoclr && count == cmp))
    |=> count == $past(count) + 1'b1);

  // R5: auto-clear returns counter to zero on match
  p_autoclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl.autoclr && !cnt_lo_we) |=> count == '0);

  // R6: low write commits staged high half
  p_atomic_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_lo_we && !cnt_hi_we) |=> count == {$past(hi_stage), $past(wdata)});

  // R2: idle counter holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && ctrl.run) && !cnt_lo_we) |=> $stable(count));

endmodule

// File: rtl/tick_irq_combine.sv
module tick_irq_combine #(
  parameter int unsigned N_SRC = 3,
  parameter int unsigned ST_W  = N_SRC + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_SRC-1:0] hit,
  input  logic [N_SRC-1:0] irq_en,
  input  logic            abort_in,
  input  logic            clr_we,
  input  logic [ST_W-1:0] clr_mask,
  output logic [ST_W-1:0] status,
  output logic            irq_n
);

  logic [ST_W-1:0] keep_mask;
  logic [ST_W-1:0] set_vec;
  logic [ST_W-1:0] live_mask;

  assign keep_mask = clr_we ? ~clr_mask : '1;
  assign set_vec   = {abort_in, hit};
  assign live_mask = {1'b1, irq_en};

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & keep_mask) | set_vec;
  end

  assign irq_n = ~|(status & live_mask);

  // R4: every match leaves its flag set
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((status[N_SRC-1:0] & $past(hit)) == $past(hit)));

  // R9: abort pulls the line low on the next cycle
  p_abort_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_in |=> !irq_n);

  // R10: without a clear write, flags never fall
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((status & $past(status)) == $past(status)));

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int unsigned N_TMR  = 3,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              abort_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic [HALF_W-1:0] reg_rdata,
  output logic              irq_n
);

  localparam int unsigned IDX_W = ADDR_W - 3;
  localparam int unsigned ST_W  = N_TMR + 1;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(N_TMR * SLOT_WORDS);

  logic [IDX_W-1:0] slot;
  logic [2:0]       field;
  assign slot  = reg_addr[ADDR_W-1:3];
  assign field = reg_addr[2:0];

  tmr_ctrl_t        ctrl_q [N_TMR];
  logic [CNT_W-1:0] cnt_q  [N_TMR];
  logic [CNT_W-1:0] cmp_q  [N_TMR];
  logic [N_TMR-1:0] hit_v;
  logic [N_TMR-1:0] ie_v;
  logic [ST_W-1:0]  status;

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    logic sel;
    assign sel     = reg_we && (slot == IDX_W'(i));
    assign ie_v[i] = ctrl_q[i].irq_en;

    tick_timer_unit #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .ctrl_we   (sel && field == F_CTRL),
      .cnt_lo_we (sel && field == F_CNT_LO),
      .cnt_hi_we (sel && field == F_CNT_HI),
      .cmp_lo_we (sel && field == F_CMP_LO),
      .cmp_hi_we (sel && field == F_CMP_HI),
      .wdata     (reg_wdata),
      .ctrl      (ctrl_q[i]),
      .count     (cnt_q[i]),
      .cmp       (cmp_q[i]),
      .hit       (hit_v[i])
    );
  end

  tick_irq_combine #(.N_SRC(N_TMR)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit_v),
    .irq_en   (ie_v),
    .abort_in (abort_in),
    .clr_we   (reg_we && reg_addr == STATUS_ADDR),
    .clr_mask (reg_wdata[ST_W-1:0]),
    .status   (status),
    .irq_n    (irq_n)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STATUS_ADDR) begin
      reg_rdata[ST_W-1:0] = status;
    end else begin
      for (int i = 0; i < N_TMR; i++) begin
        if (slot == IDX_W'(i)) begin
          case (field)
            F_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl_q[i];
            F_CNT_LO: reg_rdata = cnt_q[i][HALF_W-1:0];
            F_CNT_HI: reg_rdata = cnt_q[i][CNT_W-1:HALF_W];
            F_CMP_LO: reg_rdata = cmp_q[i][HALF_W-1:0];
            F_CMP_HI: reg_rdata = cmp_q[i][CNT_W-1:HALF_W];
            default:  reg_rdata = '0;
          endcase
        end
      end
    end
  end

  // R8: a flag with its enable set drives the line low
  p_line_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit_v & ie_v)) |=> !irq_n);

endmodule

// File: tb/tick_timer_bank_bench.sv
module tick_timer_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        abort_in = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_n;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tick_timer_bank u_tick_timer_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .abort_in(abort_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  localparam logic [4:0] ST = 5'd24;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd32(input logic [4:0] lo, output logic [31:0] v);
    logic [15:0] l, h;
    rd(lo, l);
    rd(lo + 5'd1, h);
    v = {h, l};
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int t = 0; t < 3; t++) begin
      for (int f = 0; f < 5; f++) begin
        rd(5'(t * 8 + f), d);
        chk("R1 reg", {16'h0, d}, 32'h0);
      end
    end
    rd(ST, d);
    chk("R1 status", {16'h0, d}, 32'h0);
    chk("R1 irq_n", {31'h0, irq_n}, 32'h1);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr(5'd3, 16'h0100);
    wr(5'd0, 16'h0001);
    pulse(5);
    rd32(5'd1, v); chk("R2 five ticks", v, 32'd5);
    repeat (4) @(negedge clk);
    rd32(5'd1, v); chk("R2 hold no tick", v, 32'd5);
    wr(5'd0, 16'h0000);
    pulse(3);
    rd32(5'd1, v); chk("R2 hold disabled", v, 32'd5);
  endtask

  task automatic t_atomic;
    logic [31:0] v;
    wr(5'd12, 16'h0000);
    wr(5'd10, 16'h1234);
    rd32(5'd9, v); chk("R6 high staged only", v, 32'h0);
    wr(5'd9, 16'hFFFE);
    rd32(5'd9, v); chk("R6 atomic load", v, 32'h1234FFFE);
    wr(5'd8, 16'h0001);
    pulse(2);
    rd32(5'd9, v); chk("R6 carry into high", v, 32'h12350000);
    rd32(5'd1, v); chk("R11 timer0 untouched", v, 32'd5);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    logic [15:0] d;
    wr(5'd18, 16'hFFFF);
    wr(5'd17, 16'hFFFF);
    wr(5'd16, 16'h0001);
    pulse(1);
    rd32(5'd17, v); chk("R3 wrap", v, 32'h0);
    rd(ST, d); chk("R4 no early flag", {16'h0, d}, 32'h0);
    pulse(1);
    rd(ST, d); chk("R4 match flag", {16'h0, d}, 32'h4);
    rd32(5'd17, v); chk("R3 counts past match", v, 32'd1);
    chk("R8 disabled irq stays high", {31'h0, irq_n}, 32'h1);
    wr(ST, 16'h0004);
    rd(ST, d); chk("R10 w1c", {16'h0, d}, 32'h0);
    wr(5'd16, 16'h0000);
  endtask

  task automatic t_autoclr;
    logic [31:0] v;
    logic [15:0] d;
    wr(5'd2, 16'h0000);
    wr(5'd1, 16'h0000);
    wr(5'd3, 16'h0003);
    wr(5'd4, 16'h0000);
    wr(5'd0, 16'h0007);
    pulse(3);
    rd32(5'd1, v); chk("R5 before match", v, 32'd3);
    rd(ST, d); chk("R5 no flag yet", {16'h0, d}, 32'h0);
    pulse(1);
    rd32(5'd1, v); chk("R5 cleared", v, 32'd0);
    rd(ST, d); chk("R5 flag", {16'h0, d}, 32'h1);
    chk("R8 irq low", {31'h0, irq_n}, 32'h0);
    wr(ST, 16'h0001);
    chk("R8 irq released", {31'h0, irq_n}, 32'h1);
    pulse(3);
    rd(ST, d); chk("R5 period not yet", {16'h0, d}, 32'h0);
    pulse(1);
    rd(ST, d); chk("R5 periodic flag", {16'h0, d}, 32'h1);
    wr(5'd0, 16'h0000);
    wr(ST, 16'h0001);
  endtask

  task automatic t_cmp;
    logic [31:0] v;
    wr(5'd12, 16'hABCD);
    rd32(5'd11, v); chk("R7 high only", v, 32'hABCD0000);
    wr(5'd11, 16'h0042);
    rd32(5'd11, v); chk("R7 both halves", v, 32'hABCD0042);
  endtask

  task automatic t_abort;
    logic [15:0] d;
    @(negedge clk); abort_in = 1'b1;
    @(negedge clk); abort_in = 1'b0;
    rd(ST, d); chk("R9 abort flag", {16'h0, d}, 32'h8);
    chk("R9 irq low", {31'h0, irq_n}, 32'h0);
    repeat (3) @(negedge clk);
    rd(ST, d); chk("R9 sticky", {16'h0, d}, 32'h8);
    @(negedge clk); abort_in = 1'b1;
    wr(ST, 16'h0008);
    rd(ST, d); chk("R10 set wins", {16'h0, d}, 32'h8);
    abort_in = 1'b0;
    wr(ST, 16'h0008);
    rd(ST, d); chk("R10 cleared", {16'h0, d}, 32'h0);
    chk("R8 idle high", {31'h0, irq_n}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_atomic();
    t_wrap();
    t_autoclr();
    t_cmp();
    t_abort();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule